// File: doc/BRIEF.md
# Free-Running Match Timer

This block is a system timer with a bus-side register file and a separate timer-side counter. A 32-bit up-counter advances by one on every edge of a dedicated tick clock, nominally 3 MHz, and wraps from all ones to zero. A programmable compare value raises a pending event when the counter reaches it, and an interrupt line reports that event when it is enabled.

The registers sit on a simple APB-like bus in the bus clock domain, and the counter runs on the tick clock. Three kinds of transfer cross between the two domains: loading the counter, loading the compare value, and taking a snapshot of the counter so that the bus can read it. Each of these uses a four-phase request/acknowledge handshake with two-flop synchronizers in both directions. Each has a busy flag in the access-status register, which software polls before it starts the next transfer.

Each handshake runs through three named states. HS_IDLE goes to HS_RAISE when a request is accepted. HS_RAISE goes to HS_DROP when the synchronized acknowledge is seen high. HS_DROP goes back to HS_IDLE when the acknowledge is seen low. The busy flag is high in HS_RAISE and HS_DROP. Typical use: enable counting, clear the events, write the compare value and poll its flag, then enable the interrupt. To read the time, request a snapshot, poll its flag, and read the counter register.

Top module: `match_timer`

## Requirements
- R1: After reset the compare register reads 0xFFFFFFFF. The status, interrupt-enable, control and access-status registers read 0, and irq_o is low.
- R2: While control bit 0 is 1, the counter advances by one per tick-clock edge. While control bit 0 is 0, the counter holds its value.
- R3: A write to offset 0x10 loads the counter with the written value. Access-status bit 4 is high from the write until the load has crossed into the tick domain.
- R4: Writing control bit 1 as 1 requests a snapshot of the counter. Access-status bit 5 is high from the request until the snapshot can be read at offset 0x10. Control bit 1 reads back as 0.
- R5: A write to offset 0x00 sets the compare value, and offset 0x00 reads it back. Access-status bit 0 is high until the new value has crossed into the tick domain.
- R6: A counter write, compare write or snapshot request made while its own busy bit is set is ignored.
- R7: Status bit 0 is set on the tick at which the running counter becomes equal to the compare value.
- R8: Writing a 1 to a bit of the low four status bits clears that bit. Writing 0 leaves the bit unchanged. Offset 0x14 holds the status.
- R9: irq_o is high exactly while status bit 0 and interrupt-enable bit 0 (offset 0x1C) are both 1. Writing 0 to the enable masks irq_o without clearing the status.
- R10: The counter wraps from 0xFFFFFFFF to 0 and keeps counting.
- R11: Every busy bit returns to 0 within a bounded number of cycles, set by two synchronizer round trips. The control register is at offset 0x20 and the access status at offset 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus/register clock |
| clk_tick | input | 1 | Counter tick clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Select, setup and access phases |
| bus_en | input | 1 | Access phase strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access phase |
| irq_o | output | 1 | Level interrupt |

## Verification
On every clock, the assertions check the following. An acknowledge is never seen while a handshake is idle. A stopped counter holds, and a running counter steps by exactly one. A request made while busy leaves the held compare value unchanged. A write-one clear takes effect unless a match arrives in the same cycle. A raised interrupt stays up until it is cleared or masked. Only the bench scenarios can show the end-to-end results: a loaded counter value comes back through a snapshot, a compare hit occurs at the right count, the counter wraps, and the status and interrupt respond correctly to clearing and masking.

// File: rtl/mt_pkg.sv
package mt_pkg;
    // Handshake states; bit 0 is the request line itself (no decode glitch across domains)
    typedef enum logic [1:0] {
        HS_IDLE  = 2'b00,
        HS_RAISE = 2'b01,
        HS_DROP  = 2'b10
    } hs_state_t;

    localparam int OFS_MATCH = 'h00;
    localparam int OFS_COUNT = 'h10;
    localparam int OFS_STAT  = 'h14;
    localparam int OFS_IEN   = 'h1C;
    localparam int OFS_CTRL  = 'h20;
    localparam int OFS_ACC   = 'h24;

    localparam int CH_MATCH = 0;
    localparam int CH_LOAD  = 1;
    localparam int CH_SNAP  = 2;
    localparam int NUM_CH   = 3;
endpackage

// File: rtl/mt_xfer_hs.sv
module mt_xfer_hs
    import mt_pkg::*;
(
    input  logic clk_src,
    input  logic clk_dst,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic dst_stb
);
    hs_state_t state_q, state_d;
    logic req_d1, req_d2, req_d3;
    logic ack_s1, ack_s2;

    // state register
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:  if (start)   state_d = HS_RAISE;
            HS_RAISE: if (ack_s2)  state_d = HS_DROP;
            HS_DROP:  if (!ack_s2) state_d = HS_IDLE;
            default:               state_d = HS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q != HS_IDLE);
    end

    // destination side: synchronize request, detect its rising edge
    always_ff @(posedge clk_dst or negedge rst_n) begin
        if (!rst_n) begin
            req_d1 <= 1'b0;
            req_d2 <= 1'b0;
            req_d3 <= 1'b0;
        end else begin
            req_d1 <= state_q[0];
            req_d2 <= req_d1;
            req_d3 <= req_d2;
        end
    end
    assign dst_stb = req_d2 & ~req_d3;

    // acknowledge back to the source side
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= req_d2;
            ack_s2 <= ack_s1;
        end
    end

    a_r11_ack_only_when_busy: assert property (@(posedge clk_src) disable iff (!rst_n)
        ack_s2 |-> busy);
    a_r6_busy_not_restarted: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state_q == HS_DROP && ack_s2) |=> (state_q == HS_DROP));
endmodule

// File: rtl/mt_tick_core.sv
module mt_tick_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk_tick,
    input  logic             rst_n,
    input  logic             run_async,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             match_stb,
    input  logic [CNT_W-1:0] match_val,
    input  logic             snap_stb,
    output logic [CNT_W-1:0] snap_q,
    output logic             hit_tg
);
    logic             run_s1, run_s2;
    logic [CNT_W-1:0] cnt_q, cmp_q, cnt_inc;

    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk_tick or negedge rst_n) begin
        if (!rst_n) begin
            run_s1 <= 1'b0;
            run_s2 <= 1'b0;
            cnt_q  <= '0;
            cmp_q  <= '1;
            snap_q <= '0;
            hit_tg <= 1'b0;
        end else begin
            run_s1 <= run_async;
            run_s2 <= run_s1;
            if (load_stb)    cnt_q <= load_val;
            else if (run_s2) cnt_q <= cnt_inc;
            if (match_stb)   cmp_q <= match_val;
            if (snap_stb)    snap_q <= cnt_q;
            if (run_s2 && !load_stb && cnt_inc == cmp_q) hit_tg <= ~hit_tg;
        end
    end

    a_r2_holds_when_stopped: assert property (@(posedge clk_tick) disable iff (!rst_n)
        (!run_s2 && !load_stb) |=> $stable(cnt_q));
    a_r10_steps_by_one: assert property (@(posedge clk_tick) disable iff (!rst_n)
        (run_s2 && !load_stb) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/match_timer.sv
module match_timer
    import mt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk_bus,
    input  logic              clk_tick,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int ST_W = 4;

    logic [NUM_CH-1:0] start, busy, dst_stb;
    logic [CNT_W-1:0]  match_hold, load_hold, snap_q;
    logic              run_en, ien, st0;
    logic              hit_tg, hit_s1, hit_s2, hit_s3, hit_evt;
    logic              wr_acc;
    logic              wr_match, wr_count, wr_stat, wr_ien, wr_ctrl;

    assign wr_acc   = bus_sel & bus_en & bus_wr;
    assign wr_match = wr_acc && bus_addr == ADDR_W'(OFS_MATCH);
    assign wr_count = wr_acc && bus_addr == ADDR_W'(OFS_COUNT);
    assign wr_stat  = wr_acc && bus_addr == ADDR_W'(OFS_STAT);
    assign wr_ien   = wr_acc && bus_addr == ADDR_W'(OFS_IEN);
    assign wr_ctrl  = wr_acc && bus_addr == ADDR_W'(OFS_CTRL);

    assign start[CH_MATCH] = wr_match && !busy[CH_MATCH];
    assign start[CH_LOAD]  = wr_count && !busy[CH_LOAD];
    assign start[CH_SNAP]  = wr_ctrl  && bus_wdata[1] && !busy[CH_SNAP];

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_hs
            mt_xfer_hs u_hs (
                .clk_src (clk_bus),
                .clk_dst (clk_tick),
                .rst_n   (rst_n),
                .start   (start[g]),
                .busy    (busy[g]),
                .dst_stb (dst_stb[g])
            );
        end
    endgenerate

    mt_tick_core #(.CNT_W(CNT_W)) u_core (
        .clk_tick  (clk_tick),
        .rst_n     (rst_n),
        .run_async (run_en),
        .load_stb  (dst_stb[CH_LOAD]),
        .load_val  (load_hold),
        .match_stb (dst_stb[CH_MATCH]),
        .match_val (match_hold),
        .snap_stb  (dst_stb[CH_SNAP]),
        .snap_q    (snap_q),
        .hit_tg    (hit_tg)
    );

    assign hit_evt = hit_s2 ^ hit_s3;

    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            match_hold <= '1;
            load_hold  <= '0;
            run_en     <= 1'b0;
            ien        <= 1'b0;
            st0        <= 1'b0;
            hit_s1     <= 1'b0;
            hit_s2     <= 1'b0;
            hit_s3     <= 1'b0;
        end else begin
            hit_s1 <= hit_tg;
            hit_s2 <= hit_s1;
            hit_s3 <= hit_s2;
            if (start[CH_MATCH]) match_hold <= bus_wdata;
            if (start[CH_LOAD])  load_hold  <= bus_wdata;
            if (wr_ctrl)         run_en     <= bus_wdata[0];
            if (wr_ien)          ien        <= bus_wdata[0];
            if (hit_evt)                    st0 <= 1'b1;
            else if (wr_stat && bus_wdata[0]) st0 <= 1'b0;
        end
    end

    assign irq_o = st0 & ien;

    always_comb begin
        bus_rdata = '0;
        unique case (int'(bus_addr))
            OFS_MATCH: bus_rdata = match_hold;
            OFS_COUNT: bus_rdata = snap_q;
            OFS_STAT:  bus_rdata[ST_W-1:0] = {3'b000, st0};
            OFS_IEN:   bus_rdata[0] = ien;
            OFS_CTRL:  bus_rdata[0] = run_en;
            OFS_ACC:   bus_rdata[5:0] = {busy[CH_SNAP], busy[CH_LOAD], 3'b000, busy[CH_MATCH]};
            default:   bus_rdata = '0;
        endcase
    end

    a_r6_match_write_ignored: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (wr_match && busy[CH_MATCH]) |=> $stable(match_hold));
    a_r6_load_write_ignored: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (wr_count && busy[CH_LOAD]) |=> $stable(load_hold));
    a_r8_w1c_clears: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (wr_stat && bus_wdata[0] && !hit_evt) |=> !st0);
    a_r9_irq_level_held: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (irq_o && !wr_stat && !wr_ien) |=> irq_o);
    a_r7_event_sets_status: assert property (@(posedge clk_bus) disable iff (!rst_n)
        hit_evt |=> st0);
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
    logic        clk_bus = 0, clk_tick = 0, rst_n = 0;
    logic        bus_sel = 0, bus_en = 0, bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        irq_o;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #5  clk_bus  = ~clk_bus;
    always #17 clk_tick = ~clk_tick;

    match_timer u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk_bus); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_en = 0;
        @(negedge clk_bus); bus_en = 1;
        @(negedge clk_bus); bus_sel = 0; bus_en = 0; bus_wr = 0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk_bus); bus_sel = 1; bus_wr = 0; bus_addr = a; bus_en = 0;
        @(negedge clk_bus); bus_en = 1; #1 d = bus_rdata;
        @(negedge clk_bus); bus_sel = 0; bus_en = 0;
    endtask

    task automatic poll(input logic [31:0] mask, input string tag);
        logic [31:0] v;
        int n = 0;
        do begin brd(8'h24, v); n++; end while ((v & mask) != 0 && n < 100);
        chk((v & mask) == 0, tag, v & mask, 0);
    endtask

    task automatic snap(input bit run, output logic [31:0] v);
        bwr(8'h20, run ? 32'd3 : 32'd2);
        poll(32'h20, "R4 snapshot busy clears");
        brd(8'h10, v);
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk_tick);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        #23 rst_n = 1;
        // R1 reset values
        brd(8'h00, v); chk(v == 32'hFFFFFFFF, "R1 match reset", v, 32'hFFFFFFFF);
        brd(8'h14, v); chk(v == 0, "R1 status reset", v, 0);
        brd(8'h1C, v); chk(v == 0, "R1 ien reset", v, 0);
        brd(8'h20, v); chk(v == 0, "R1 ctrl reset", v, 0);
        brd(8'h24, v); chk(v == 0, "R1 access reset", v, 0);
        chk(irq_o == 0, "R1 irq reset", irq_o, 0);

        // R3 counter load while stopped, R4 snapshot
        bwr(8'h10, 32'h0000_1234);
        brd(8'h24, v); chk(v[4] == 1, "R3 load busy set", v[4], 1);
        poll(32'h10, "R11 load busy clears");
        bwr(8'h20, 32'd2);
        brd(8'h24, v); chk(v[5] == 1, "R4 snapshot busy set", v[5], 1);
        poll(32'h20, "R11 snapshot busy clears");
        brd(8'h10, v); chk(v == 32'h1234, "R3 R4 loaded value", v, 32'h1234);
        brd(8'h20, v); chk(v == 0, "R4 ctrl bit1 reads 0", v, 0);

        // R6 request while busy ignored
        bwr(8'h10, 32'h0000_2222);
        bwr(8'h10, 32'h0000_5555);
        poll(32'h10, "R11 load busy clears");
        snap(0, v); chk(v == 32'h2222, "R6 second load ignored", v, 32'h2222);
        bwr(8'h00, 32'h0000_AAAA);
        bwr(8'h00, 32'h0000_BBBB);
        brd(8'h24, v); chk(v[0] == 1, "R5 match busy set", v[0], 1);
        poll(32'h01, "R11 match busy clears");
        brd(8'h00, v); chk(v == 32'hAAAA, "R6 R5 second match ignored", v, 32'hAAAA);

        // R2 counting and holding
        bwr(8'h20, 32'd1); ticks(20);
        snap(1, a); ticks(20); snap(1, b);
        chk(b > a && (b - a) < 100, "R2 counter advances", b - a, 20);
        bwr(8'h20, 32'd0); ticks(5);
        snap(0, a); ticks(15); snap(0, b);
        chk(a == b, "R2 counter holds when stopped", b, a);

        // R10 wrap
        bwr(8'h10, 32'hFFFF_FFF0); poll(32'h10, "R11 load busy clears");
        bwr(8'h20, 32'd1); ticks(40);
        bwr(8'h20, 32'd0); ticks(5);
        snap(0, v); chk(v < 32'h100, "R10 counter wraps", v, 32'h20);

        // R7 R8 R9 match event
        bwr(8'h00, 32'h0000_0100); poll(32'h01, "R11 match busy clears");
        bwr(8'h10, 32'h0000_00F0); poll(32'h10, "R11 load busy clears");
        bwr(8'h14, 32'hF);
        brd(8'h14, v); chk(v == 0, "R7 no event before run", v, 0);
        bwr(8'h20, 32'd1); ticks(40);
        bwr(8'h20, 32'd0); ticks(5);
        brd(8'h14, v); chk(v == 1, "R7 match sets status", v, 1);
        chk(irq_o == 0, "R9 irq masked", irq_o, 0);
        bwr(8'h1C, 32'd1);
        chk(irq_o == 1, "R9 irq raised", irq_o, 1);
        bwr(8'h14, 32'h0);
        brd(8'h14, v); chk(v == 1, "R8 write 0 no effect", v, 1);
        chk(irq_o == 1, "R8 irq still set", irq_o, 1);
        bwr(8'h1C, 32'd0);
        chk(irq_o == 0, "R9 mask drops irq", irq_o, 0);
        brd(8'h14, v); chk(v == 1, "R9 mask keeps status", v, 1);
        bwr(8'h1C, 32'd1);
        bwr(8'h14, 32'hF);
        brd(8'h14, v); chk(v == 0, "R8 w1c clears", v, 0);
        chk(irq_o == 0, "R9 irq cleared", irq_o, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule